// File: doc/BRIEF.md
# Write-Only I2C Voltage-Setting Slave

This block is a receive-only I2C target that keeps one output-voltage setting for a step-down regulator. It watches the two bus wires through synchronizers, finds START and STOP conditions, and compares the first byte of each transfer with a fixed 7-bit device address. When the address matches and the direction bit asks for a write, it pulls SDA low for the acknowledge clock. It then takes exactly one data byte. A code from 0 to 28 selects 0.6 V plus 50 mV per step. Such a code is acknowledged and stored, and a one-cycle strobe announces it. Larger codes, reads and foreign addresses receive no acknowledge and leave the setting untouched.

The stored code leaves the block as a valid-only stream: `vset_valid` pulses for one clock when `vset_code` takes a new value. There is no ready input. An I2C target without clock stretching cannot hold the bus, so back-pressure is impossible and the consumer must take every strobe. Between strobes `vset_code` holds its value and may be read at any time.

A separate enable qualifier turns the regulator on as soon as its pin goes high. It turns the regulator off only after the pin has stayed low for a parameterised number of clocks. The default is 50000 cycles, which is 500 µs at 100 MHz. A short low glitch therefore never disables the output.

Top module: `i2c_vset_slave`

## Requirements
- R1: After reset, vset_code is 0, vset_valid is 0, sda_oe is 0 and en_out is 0.
- R2: A first byte made of the 7-bit address 7'h14, sent MSB first, followed by a 0 in bit 0 (write) is acknowledged: sda_oe is 1 while SCL is high in the ninth clock.
- R3: A first byte with any other address, or with bit 0 equal to 1 (read), is not acknowledged, and the rest of that transfer changes nothing.
- R4: After an acknowledged address, a data byte of value 0 to 28 is acknowledged in its ninth clock. At the falling SCL edge ending that clock, vset_code takes the byte value and vset_valid is 1 for exactly one clock.
- R5: A data byte of value 29 or above is not acknowledged, and vset_code and vset_valid are unaffected.
- R6: A START or STOP received before the eighth data bit completes aborts the byte and leaves vset_code unchanged. After a repeated START, the next byte is decoded as an address.
- R7: Only the first data byte of a transfer is taken; later bytes before the next START are neither acknowledged nor stored.
- R8: en_out becomes 1 at most 3 clocks after en_pin goes high.
- R9: en_out becomes 0 only after en_pin has been low for OFF_CYCLES consecutive clocks, counted from the synchronizer output, so the fall comes OFF_CYCLES+2 clocks after the pin falls. A low pulse shorter than that has no effect on en_out.
- R10: vset_code changes only in a cycle where vset_valid is 1, and a valid code is never above 28.
- R11: sda_oe is 0 outside the two acknowledge clocks, including while the master drives address and data bits and while the bus is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock wire level |
| sda_i | input | 1 | Bus data wire level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain); 0 releases it |
| en_pin | input | 1 | Raw regulator enable pin |
| vset_code | output | 8 | Stored voltage code (0.6 V + code x 50 mV) |
| vset_valid | output | 1 | One-cycle strobe: a new code was committed |
| en_out | output | 1 | Qualified enable |

## Verification
The assertions assume that every SCL low phase lasts longer than the synchronizer and edge-detect latency of three clocks. The acknowledge drive then rises and falls while SCL is still low. They also assume that the master moves SDA only while SCL is low, except to form START and STOP. The bench drives the bus with eight system clocks per quarter bit period, changes SDA only in the low phase, and ANDs the master drive with the inverse of `sda_oe` to model the open-drain wire. Random addresses, direction bits and data codes are mixed with directed aborts, second bytes and enable pulses on both sides of the latch interval.

// File: rtl/i2c_vset_pkg.sv
package i2c_vset_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_SKIP
  } rx_state_t;
endpackage

// File: rtl/i2c_vset_sync.sv
module i2c_vset_sync #(
  parameter int W        = 1,
  parameter int STAGES   = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe[0] <= {W{RST_VAL}};
    else        pipe[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= {W{RST_VAL}};
      else        pipe[s] <= pipe[s-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/i2c_vset_rx.sv
module i2c_vset_rx
  import i2c_vset_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h14,
  parameter int         MAX_CODE = 28,
  parameter int         CODE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sda,
  output logic              sda_oe,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o
);
  localparam logic [CODE_W-1:0] CODE_LIMIT = CODE_W'(MAX_CODE);

  rx_state_t         state;
  logic              scl_q, sda_q, byte_full;
  logic [7:0]        shreg;
  logic [2:0]        bit_cnt;
  logic              scl_rise, scl_fall, bus_start, bus_stop;

  assign scl_rise  = scl && !scl_q;
  assign scl_fall  = !scl && scl_q;
  assign bus_start = scl && scl_q && sda_q && !sda;
  assign bus_stop  = scl && scl_q && !sda_q && sda;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      byte_full <= 1'b0;
      shreg     <= '0;
      bit_cnt   <= '0;
      sda_oe    <= 1'b0;
      code_o    <= '0;
      valid_o   <= 1'b0;
    end else begin
      scl_q   <= scl;
      sda_q   <= sda;
      valid_o <= 1'b0;
      if (bus_start) begin
        state     <= ST_ADDR;
        bit_cnt   <= '0;
        byte_full <= 1'b0;
        sda_oe    <= 1'b0;
      end else if (bus_stop) begin
        state     <= ST_IDLE;
        byte_full <= 1'b0;
        sda_oe    <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_DATA: begin
            if (scl_rise && !byte_full) begin
              shreg <= {shreg[6:0], sda};
              if (bit_cnt == 3'd7) byte_full <= 1'b1;
              else                 bit_cnt   <= bit_cnt + 3'd1;
            end else if (scl_fall && byte_full) begin
              byte_full <= 1'b0;
              bit_cnt   <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR && !shreg[0]) begin
                  state  <= ST_ADDR_ACK;
                  sda_oe <= 1'b1;
                end else begin
                  state <= ST_SKIP;
                end
              end else if (CODE_W'(shreg) <= CODE_LIMIT) begin
                state  <= ST_DATA_ACK;
                sda_oe <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ADDR_ACK: if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_DATA;
          end
          ST_DATA_ACK: if (scl_fall) begin
            sda_oe  <= 1'b0;
            code_o  <= CODE_W'(shreg);
            valid_o <= 1'b1;
            state   <= ST_SKIP;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_vset_enq.sv
module i2c_vset_enq #(
  parameter int OFF_CYCLES = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_s,
  output logic en_out
);
  localparam int CNT_W = $clog2(OFF_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OFF_CYCLES - 1);

  logic [CNT_W-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt <= '0;
      en_out  <= 1'b0;
    end else if (en_s) begin
      low_cnt <= '0;
      en_out  <= 1'b1;
    end else if (low_cnt == LAST) begin
      en_out  <= 1'b0;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_vset_slave.sv
module i2c_vset_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h14,
  parameter int         MAX_CODE    = 28,
  parameter int         CODE_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter int         OFF_CYCLES  = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              en_pin,
  output logic [CODE_W-1:0] vset_code,
  output logic              vset_valid,
  output logic              en_out
);
  logic [1:0] bus_s;
  logic       en_s;

  i2c_vset_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d_i({scl_i, sda_i}), .q_o(bus_s)
  );

  i2c_vset_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_en_sync (
    .clk(clk), .rst_n(rst_n), .d_i(en_pin), .q_o(en_s)
  );

  i2c_vset_rx #(.DEV_ADDR(DEV_ADDR), .MAX_CODE(MAX_CODE), .CODE_W(CODE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .scl(bus_s[1]), .sda(bus_s[0]),
    .sda_oe(sda_oe), .code_o(vset_code), .valid_o(vset_valid)
  );

  i2c_vset_enq #(.OFF_CYCLES(OFF_CYCLES)) u_enq (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .en_out(en_out)
  );
endmodule

// File: rtl/i2c_vset_checker.sv
module i2c_vset_checker #(
  parameter int MAX_CODE   = 28,
  parameter int CODE_W     = 8,
  parameter int OFF_CYCLES = 50000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic              en_pin,
  input logic [CODE_W-1:0] vset_code,
  input logic              vset_valid,
  input logic              en_out
);
  localparam int LW = $clog2(OFF_CYCLES + 4);
  localparam logic [LW-1:0] LO_SAT = LW'(OFF_CYCLES + 3);

  logic [1:0]    hi_run;
  logic [LW-1:0] lo_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_run <= '0;
      lo_run <= '0;
    end else begin
      hi_run <= en_pin ? ((hi_run == 2'd3) ? hi_run : hi_run + 2'd1) : 2'd0;
      lo_run <= en_pin ? '0 : ((lo_run == LO_SAT) ? lo_run : lo_run + 1'b1);
    end
  end

  AST_CODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    vset_valid |-> (vset_code <= CODE_W'(MAX_CODE))); // R10
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !vset_valid |-> $stable(vset_code)); // R10
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    vset_valid |=> !vset_valid); // R4
  AST_EN_FAST_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_run == 2'd3) |-> en_out); // R8
  AST_EN_LATCHED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_out) |-> (lo_run >= LW'(OFF_CYCLES))); // R9
  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) || $fell(sda_oe)) |-> !scl_i); // R11
endmodule

bind i2c_vset_slave i2c_vset_checker #(
  .MAX_CODE(MAX_CODE), .CODE_W(CODE_W), .OFF_CYCLES(OFF_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .en_pin(en_pin),
  .vset_code(vset_code), .vset_valid(vset_valid), .en_out(en_out)
);

// File: tb/tb_i2c_vset_slave.sv
module tb_i2c_vset_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int OFF        = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, en_pin = 1'b0;
  logic sda_oe, vset_valid, en_out;
  logic [7:0] vset_code;
  logic sda_line;

  int errors = 0, checks = 0, n_valid = 0, oe_bad = 0;
  bit done = 1'b0;
  logic [7:0] exp_code = 8'd0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_vset_slave #(.OFF_CYCLES(OFF)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .en_pin(en_pin), .vset_code(vset_code), .vset_valid(vset_valid), .en_out(en_out)
  );

  always @(negedge clk) if (rst_n && vset_valid) n_valid++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic qw(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit f_addr_ok(input logic [6:0] a, input bit rw);
    return (a == 7'h14) && !rw;
  endfunction

  function automatic bit f_data_ok(input logic [7:0] d);
    return d <= 8'd28;
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; qw(Q); scl_m = 1'b1; qw(Q); sda_m = 1'b0; qw(Q); scl_m = 1'b0; qw(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(Q); scl_m = 1'b1; qw(Q); sda_m = 1'b1; qw(2*Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qw(Q); scl_m = 1'b1; qw(Q);
      if (sda_oe) oe_bad++;
      qw(Q); scl_m = 1'b0; qw(Q);
    end
  endtask

  task automatic write_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; qw(Q); scl_m = 1'b1; qw(Q);
    ack = sda_oe;
    qw(Q); scl_m = 1'b0; qw(Q);
  endtask

  task automatic xfer(input logic [6:0] a, input bit rw, input logic [7:0] d,
                      input string tag);
    bit aa, da;
    int nv;
    bit ea, ed;
    nv = n_valid;
    ea = f_addr_ok(a, rw);
    ed = ea && f_data_ok(d);
    bus_start();
    write_byte({a, rw}, aa);
    write_byte(d, da);
    bus_stop();
    if (ed) exp_code = d;
    chk(aa == ea, ea ? "R2 address ack" : "R3 address nack", aa, ea);
    chk(da == ed, ed ? {"R4 data ack ", tag} : {"R5 data nack ", tag}, da, ed);
    chk(vset_code == exp_code, "R4 stored code", vset_code, exp_code);
    chk(n_valid - nv == int'(ed), "R10 valid strobe count", n_valid - nv, int'(ed));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit a1, a2;
    int nv;
    void'($urandom(32'd20240611));
    qw(5);
    rst_n = 1'b1;
    qw(2);
    chk(vset_code == 8'd0, "R1 reset code", vset_code, 0);
    chk(vset_valid == 1'b0, "R1 reset valid", vset_valid, 0);
    chk(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
    chk(en_out == 1'b0, "R1 reset en_out", en_out, 0);

    // directed codes: boundaries, read bit, foreign address
    xfer(7'h14, 1'b0, 8'd28, "max");
    xfer(7'h14, 1'b0, 8'd0, "zero");
    xfer(7'h14, 1'b0, 8'd29, "over");
    xfer(7'h14, 1'b0, 8'd255, "top");
    xfer(7'h14, 1'b1, 8'd7, "read");
    xfer(7'h15, 1'b0, 8'd7, "foreign");
    xfer(7'h0A, 1'b0, 8'd7, "shifted");
    chk(sda_oe == 1'b0, "R11 idle release", sda_oe, 0);

    // R7: second byte ignored
    nv = n_valid;
    bus_start(); write_byte({7'h14, 1'b0}, a1); write_byte(8'd5, a1); write_byte(8'd7, a2); bus_stop();
    exp_code = 8'd5;
    chk(a2 == 1'b0, "R7 second byte nack", a2, 0);
    chk(vset_code == 8'd5, "R7 second byte not stored", vset_code, 5);
    chk(n_valid - nv == 1, "R7 single strobe", n_valid - nv, 1);

    // R6: STOP mid-byte
    nv = n_valid;
    bus_start(); write_byte({7'h14, 1'b0}, a1); send_bits(8'd3, 4); bus_stop();
    chk(vset_code == 8'd5, "R6 stop abort keeps code", vset_code, 5);
    chk(n_valid == nv, "R6 stop abort no strobe", n_valid - nv, 0);

    // R6: repeated START mid-byte, then a full write
    bus_start(); write_byte({7'h14, 1'b0}, a1); send_bits(8'd3, 5);
    bus_start(); write_byte({7'h14, 1'b0}, a1); write_byte(8'd9, a2); bus_stop();
    exp_code = 8'd9;
    chk(a1 == 1'b1, "R6 address after repeated start", a1, 1);
    chk(vset_code == 8'd9, "R6 code after repeated start", vset_code, 9);
    chk(n_valid - nv == 1, "R6 strobes", n_valid - nv, 1);

    // random transfers
    for (int k = 0; k < 40; k++) begin
      logic [6:0] a;
      bit rw;
      logic [7:0] d;
      a  = ($urandom % 2) ? 7'h14 : 7'($urandom);
      rw = ($urandom % 4) == 0;
      d  = 8'($urandom % 40);
      xfer(a, rw, d, "random");
    end
    chk(oe_bad == 0, "R11 no drive during master bits", oe_bad, 0);

    // R8 fast turn-on
    en_pin = 1'b1; qw(4);
    chk(en_out == 1'b1, "R8 en_out on", en_out, 1);
    // R9 short low pulse
    en_pin = 1'b0;
    for (int i = 0; i < OFF - 5; i++) begin
      qw(1);
      if (!en_out) oe_bad += 1000;
    end
    en_pin = 1'b1; qw(6);
    chk(oe_bad < 1000 && en_out, "R9 short low ignored", en_out, 1);
    // R9 long low
    en_pin = 1'b0; qw(OFF - 1);
    chk(en_out == 1'b1, "R9 still on before latch", en_out, 1);
    qw(5);
    chk(en_out == 1'b0, "R9 off after latch", en_out, 0);
    en_pin = 1'b1; qw(3);
    chk(en_out == 1'b1, "R8 en_out on again", en_out, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule